// File: doc/BRIEF.md
# Y-Extended 32-Bit Divider with Saturation

This block divides a 64-bit dividend by a 32-bit divisor over many cycles. The dividend is built from two 32-bit inputs. The upper half comes from a Y register value and the lower half from operand A. Operand B is the divisor. A mode input selects unsigned or two's-complement division. Signed division truncates toward zero.

The block returns a 64-bit result, but every quotient is forced into a 32-bit range. In unsigned mode a quotient that needs more than 32 bits becomes the largest 32-bit unsigned value, zero-extended. In signed mode a quotient too large for 32 signed bits becomes the most positive or the most negative 32-bit value, sign-extended. A zero divisor ends the operation early with a fault, and it writes no result. When the flag-setting select is high, an overflow flag records whether the result was clamped.

A caller pulses `start` while `busy` is low. It then waits for the one-cycle `done` pulse. The engine retires one quotient bit per clock cycle.

Top module: `divy_unit`

## Requirements
- R1: In unsigned mode the dividend is {op_y, op_a} and the divisor is op_b, both taken as unsigned. When the quotient is below 2^32, result is that quotient zero-extended to 64 bits.
- R2: In unsigned mode, a quotient with any bit set in positions 63..32 gives result 0x00000000FFFFFFFF.
- R3: In signed mode, {op_y, op_a} and op_b are two's-complement values. The quotient truncates toward zero. Its sign is the XOR of the dividend and divisor signs. A quotient inside [-2^31, 2^31-1] is returned sign-extended to 64 bits.
- R4: In signed mode, a positive quotient above 2^31-1 gives result 0x000000007FFFFFFF.
- R5: In signed mode, a negative quotient below -2^31 gives result 0xFFFFFFFF80000000.
- R6: A zero op_b makes div_zero go high together with done. In that case result and ovf keep their previous values.
- R7: On a completion with set_flags high and a nonzero divisor, ovf becomes 1 if R2, R4 or R5 clamped the result, and 0 otherwise.
- R8: On a completion with set_flags low, ovf keeps its previous value.
- R9: A start is accepted on a rising edge while busy is low. For a nonzero divisor, done is high for exactly one cycle, starting after the 65th rising edge that follows the accepting edge. For a zero divisor, done starts after the first rising edge that follows it. busy is high from the accepting edge until done rises.
- R10: A start while busy is high is ignored. The running operation completes with its own operands, and no second operation follows.
- R11: After reset, busy, done, div_zero and ovf are 0 and result is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request to begin a division |
| op_y | input | 32 | Upper half of the dividend |
| op_a | input | 32 | Lower half of the dividend |
| op_b | input | 32 | Divisor |
| signed_op | input | 1 | 1 selects two's-complement division |
| set_flags | input | 1 | 1 lets this operation update ovf |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 64 | Clamped quotient |
| ovf | output | 1 | Overflow flag from the last flag-setting completion |
| div_zero | output | 1 | Divide-by-zero fault, valid with done |

## Verification
The cases hardest to reach are those right at the clamp edges. An exact 2^32-1 unsigned quotient must not saturate, and a quotient of exactly -2^31 has the same bit pattern as the negative clamp and differs from it only in ovf. The stimulus reaches these cases by choosing op_y and op_a relative to op_b: op_y = op_b-1 with op_a all ones for the unsigned edge, and a dividend of -2^31 or -2^31-1 over a divisor of one for the signed edge. A dividend of -2^63 over -1 drives the magnitude path to its widest value. A second start is injected in the middle of a run to show that it is dropped.

// File: rtl/divy_pkg.sv
package divy_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } divy_state_e;

  // Attributes of the operation in flight, captured when start is accepted
  typedef struct packed {
    logic signed_op;
    logic set_flags;
    logic neg_quo;
    logic zero_div;
  } divy_job_t;

endpackage

// File: rtl/divy_prep.sv
module divy_prep #(
  parameter int W = 32
) (
  input  logic [W-1:0]   y_hi,
  input  logic [W-1:0]   a_lo,
  input  logic [W-1:0]   divisor,
  input  logic           signed_op,
  output logic [2*W-1:0] num_mag,
  output logic [W-1:0]   den_mag,
  output logic           neg_quo,
  output logic           den_zero
);
  localparam int NW = 2 * W;

  function automatic logic [NW-1:0] mag_wide(input logic [NW-1:0] v, input logic flip);
    return flip ? (~v + {{(NW-1){1'b0}}, 1'b1}) : v;
  endfunction

  function automatic logic [W-1:0] mag_narrow(input logic [W-1:0] v, input logic flip);
    return flip ? (~v + {{(W-1){1'b0}}, 1'b1}) : v;
  endfunction

  logic [NW-1:0] num_raw;
  logic          num_neg;
  logic          den_neg;

  always_comb begin
    num_raw  = {y_hi, a_lo};
    num_neg  = signed_op & num_raw[NW-1];
    den_neg  = signed_op & divisor[W-1];
    num_mag  = mag_wide(num_raw, num_neg);
    den_mag  = mag_narrow(divisor, den_neg);
    neg_quo  = num_neg ^ den_neg;
    den_zero = (divisor == '0);
  end
endmodule

// File: rtl/divy_iter.sv
module divy_iter #(
  parameter int W = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic           run,
  input  logic [2*W-1:0] num,
  input  logic [W-1:0]   den,
  output logic [2*W-1:0] quo,
  output logic           last_step
);
  localparam int NW   = 2 * W;
  localparam int ITER = NW;
  localparam int CW   = $clog2(ITER + 1);

  typedef struct packed {
    logic [W-1:0]  r;
    logic [NW-1:0] q;
  } pair_t;

  // One restoring step: shift the partial remainder left by one bit, then
  // subtract the divisor when it fits
  function automatic pair_t shift_sub(input pair_t p, input logic [W-1:0] d);
    logic [W:0] wide;
    pair_t      o;
    wide = {p.r, p.q[NW-1]};
    o.q  = {p.q[NW-2:0], 1'b0};
    if (wide >= {1'b0, d}) begin
      wide   = wide - {1'b0, d};
      o.q[0] = 1'b1;
    end
    o.r = wide[W-1:0];
    return o;
  endfunction

  pair_t         acc;
  pair_t         acc_next;
  logic [W-1:0]  den_r;
  logic [CW-1:0] cnt;

  always_comb acc_next = shift_sub(acc, den_r);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc   <= '0;
      den_r <= '0;
      cnt   <= '0;
    end else if (load) begin
      acc.q <= num;
      acc.r <= '0;
      den_r <= den;
      cnt   <= '0;
    end else if (run) begin
      acc <= acc_next;
      cnt <= cnt + CW'(1);
    end
  end

  assign quo       = acc.q;
  assign last_step = run && (cnt == CW'(ITER - 1));
endmodule

// File: rtl/divy_post.sv
module divy_post #(
  parameter int W = 32
) (
  input  logic [2*W-1:0] quo_mag,
  input  logic           neg_quo,
  input  logic           signed_op,
  output logic [2*W-1:0] value,
  output logic           saturated
);
  localparam int NW = 2 * W;
  localparam logic [NW-1:0] U_MAX   = {{W{1'b0}}, {W{1'b1}}};
  localparam logic [NW-1:0] S_MAX   = {{(W+1){1'b0}}, {(W-1){1'b1}}};
  localparam logic [NW-1:0] S_MIN   = {{(W+1){1'b1}}, {(W-1){1'b0}}};
  localparam logic [NW-1:0] NEG_LIM = {{W{1'b0}}, 1'b1, {(W-1){1'b0}}};

  function automatic logic [NW:0] clamp_u(input logic [NW-1:0] q);
    if (q[NW-1:W] != '0) return {1'b1, U_MAX};
    return {1'b0, q};
  endfunction

  function automatic logic [NW:0] clamp_s(input logic [NW-1:0] q, input logic neg);
    if (!neg && (q > S_MAX))   return {1'b1, S_MAX};
    if (neg && (q > NEG_LIM))  return {1'b1, S_MIN};
    if (neg)                   return {1'b0, ~q + {{(NW-1){1'b0}}, 1'b1}};
    return {1'b0, q};
  endfunction

  logic [NW:0] packed_out;

  always_comb begin
    packed_out = signed_op ? clamp_s(quo_mag, neg_quo) : clamp_u(quo_mag);
    saturated  = packed_out[NW];
    value      = packed_out[NW-1:0];
  end
endmodule

// File: rtl/divy_unit.sv
module divy_unit #(
  parameter int W = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [W-1:0]   op_y,
  input  logic [W-1:0]   op_a,
  input  logic [W-1:0]   op_b,
  input  logic           signed_op,
  input  logic           set_flags,
  output logic           busy,
  output logic           done,
  output logic [2*W-1:0] result,
  output logic           ovf,
  output logic           div_zero
);
  import divy_pkg::*;

  localparam int NW = 2 * W;

  divy_state_e   state;
  divy_job_t     job;

  logic [NW-1:0] num_mag;
  logic [W-1:0]  den_mag;
  logic          neg_quo;
  logic          den_zero;
  logic [NW-1:0] quo;
  logic          last_step;
  logic [NW-1:0] post_value;
  logic          post_sat;

  // Named events, also watched by the bound checker
  logic accept;
  logic step_fire;
  logic finish_fire;
  logic run_signed;

  assign accept      = (state == ST_IDLE) && start;
  assign step_fire   = (state == ST_RUN);
  assign finish_fire = (state == ST_FIN);
  assign run_signed  = job.signed_op;
  assign busy        = (state != ST_IDLE);

  divy_prep #(.W(W)) u_prep (
    .y_hi      (op_y),
    .a_lo      (op_a),
    .divisor   (op_b),
    .signed_op (signed_op),
    .num_mag   (num_mag),
    .den_mag   (den_mag),
    .neg_quo   (neg_quo),
    .den_zero  (den_zero)
  );

  divy_iter #(.W(W)) u_iter (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (accept),
    .run       (step_fire),
    .num       (num_mag),
    .den       (den_mag),
    .quo       (quo),
    .last_step (last_step)
  );

  divy_post #(.W(W)) u_post (
    .quo_mag   (quo),
    .neg_quo   (job.neg_quo),
    .signed_op (job.signed_op),
    .value     (post_value),
    .saturated (post_sat)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      job   <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (start) begin
          job.signed_op <= signed_op;
          job.set_flags <= set_flags;
          job.neg_quo   <= neg_quo;
          job.zero_div  <= den_zero;
          state         <= den_zero ? ST_FIN : ST_RUN;
        end
        ST_RUN:  if (last_step) state <= ST_FIN;
        ST_FIN:  state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done     <= 1'b0;
      div_zero <= 1'b0;
      result   <= '0;
      ovf      <= 1'b0;
    end else begin
      done     <= finish_fire;
      div_zero <= finish_fire && job.zero_div;
      if (finish_fire && !job.zero_div) begin
        result <= post_value;
        if (job.set_flags) ovf <= post_sat;
      end
    end
  end
endmodule

// File: rtl/divy_unit_chk.sv
module divy_unit_chk #(
  parameter int W = 32
) (
  input logic           clk,
  input logic           rst_n,
  input logic           busy,
  input logic           done,
  input logic           div_zero,
  input logic [2*W-1:0] result,
  input logic           ovf,
  input logic           run_signed,
  input logic           accept,
  input logic           step_fire
);
  localparam int NW = 2 * W;

  logic [15:0] steps;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         steps <= '0;
    else if (accept)    steps <= '0;
    else if (step_fire) steps <= steps + 16'd1;
  end

  p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  p_busy_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
  p_step_total_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !div_zero) |-> (steps == 16'(NW)));
  p_fault_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
    div_zero |-> done);
  p_fault_result_r6: assert property (@(posedge clk) disable iff (!rst_n)
    div_zero |-> $stable(result));
  p_fault_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    div_zero |-> $stable(ovf));
  p_unsigned_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !div_zero && !run_signed) |-> (result[NW-1:W] == '0));
  p_signed_ext_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !div_zero && run_signed) |->
      ($countones(result[NW-1:W-1]) == 0 || $countones(result[NW-1:W-1]) == W + 1));
endmodule

bind divy_unit divy_unit_chk #(.W(W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .busy       (busy),
  .done       (done),
  .div_zero   (div_zero),
  .result     (result),
  .ovf        (ovf),
  .run_signed (run_signed),
  .accept     (accept),
  .step_fire  (step_fire)
);

// File: tb/divy_unit_test.sv
`timescale 1ns/100ps
module divy_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] op_y = '0, op_a = '0, op_b = '0;
  logic        signed_op = 1'b0, set_flags = 1'b0;
  logic        busy, done, ovf, div_zero;
  logic [63:0] result;

  int checks = 0;
  int errors = 0;
  logic exp_ovf = 1'b0;
  logic [63:0] exp_res = '0;

  always #2.5 clk = ~clk;

  divy_unit uut (
    .clk(clk), .rst_n(rst_n), .start(start), .op_y(op_y), .op_a(op_a), .op_b(op_b),
    .signed_op(signed_op), .set_flags(set_flags), .busy(busy), .done(done),
    .result(result), .ovf(ovf), .div_zero(div_zero)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic void model(input logic [31:0] y, input logic [31:0] a, input logic [31:0] b,
                                input logic sg, output logic [63:0] r, output logic s);
    logic [63:0] n, mn, q;
    logic [31:0] md;
    logic        neg;
    n = {y, a};
    if (!sg) begin
      q = n / {32'h0, b};
      s = (q[63:32] != 0);
      r = s ? 64'h0000_0000_FFFF_FFFF : q;
    end else begin
      neg = n[63] ^ b[31];
      mn  = n[63] ? -n : n;
      md  = b[31] ? -b : b;
      q   = mn / {32'h0, md};
      if (!neg && q > 64'h7FFF_FFFF) begin
        r = 64'h0000_0000_7FFF_FFFF; s = 1'b1;
      end else if (neg && q > 64'h8000_0000) begin
        r = 64'hFFFF_FFFF_8000_0000; s = 1'b1;
      end else begin
        s = 1'b0; r = neg ? -q : q;
      end
    end
  endfunction

  task automatic do_div(input logic [31:0] y, input logic [31:0] a, input logic [31:0] b,
                        input logic sg, input logic sf, output int lat, output logic busy1);
    @(negedge clk);
    op_y = y; op_a = a; op_b = b; signed_op = sg; set_flags = sf; start = 1'b1;
    lat = 0; busy1 = 1'b0;
    while (1) begin
      @(negedge clk);
      lat++;
      start = 1'b0;
      if (lat == 1) busy1 = busy;
      if (done || lat > 300) break;
    end
  endtask

  task automatic run_check(input logic [31:0] y, input logic [31:0] a, input logic [31:0] b,
                           input logic sg, input logic sf, input string req);
    int lat; logic b1; logic s;
    model(y, a, b, sg, exp_res, s);
    if (sf) exp_ovf = s;
    do_div(y, a, b, sg, sf, lat, b1);
    chk(result == exp_res, req, result, exp_res);
    chk(ovf == exp_ovf && !div_zero, {req, " ovf/fault"}, {62'h0, div_zero, ovf}, {63'h0, exp_ovf});
    chk(lat == 66 && b1, "R9 latency", 64'(lat), 64'd66);
  endtask

  task automatic t_reset;
    chk(!busy && !done && !div_zero && !ovf && result == 0, "R11 reset state",
        {result[63:4], busy, done, div_zero, ovf}, 64'h0);
  endtask

  task automatic t_unsigned_basic;
    run_check(32'h0, 32'd100, 32'd7, 1'b0, 1'b1, "R1 small");
    run_check(32'h1, 32'h0, 32'd2, 1'b0, 1'b1, "R1 Y used");
    run_check(32'd4, 32'h1234_5678, 32'd9, 1'b0, 1'b1, "R1 mixed");
    run_check(32'd9, 32'hFFFF_FFFF, 32'd10, 1'b0, 1'b1, "R1 max fit");
    chk(result == 64'h0000_0000_FFFF_FFFF && !ovf, "R1 edge 2^32-1 no clamp", result, 64'hFFFF_FFFF);
  endtask

  task automatic t_unsigned_sat;
    run_check(32'd10, 32'h0, 32'd10, 1'b0, 1'b1, "R2 just over");
    chk(ovf == 1'b1, "R7 unsigned ovf set", {63'h0, ovf}, 64'h1);
    run_check(32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'd1, 1'b0, 1'b1, "R2 huge");
  endtask

  task automatic t_signed_basic;
    run_check(32'hFFFF_FFFF, 32'hFFFF_FFF9, 32'd2, 1'b1, 1'b1, "R3 -7/2");
    chk(result == 64'hFFFF_FFFF_FFFF_FFFD, "R3 truncate toward zero", result, 64'hFFFF_FFFF_FFFF_FFFD);
    run_check(32'hFFFF_FFFF, 32'hFFFF_FFF9, 32'hFFFF_FFFE, 1'b1, 1'b1, "R3 -7/-2");
    run_check(32'h0, 32'd7, 32'hFFFF_FFFE, 1'b1, 1'b1, "R3 7/-2");
    run_check(32'h0, 32'h7FFF_FFFF, 32'd1, 1'b1, 1'b1, "R3 max positive fits");
    run_check(32'hFFFF_FFFF, 32'h8000_0000, 32'd1, 1'b1, 1'b1, "R3 min negative fits");
    chk(ovf == 1'b0, "R7 -2^31 not flagged", {63'h0, ovf}, 64'h0);
  endtask

  task automatic t_signed_sat;
    run_check(32'h0, 32'h8000_0000, 32'd1, 1'b1, 1'b1, "R4 2^31");
    chk(ovf == 1'b1, "R7 signed pos ovf", {63'h0, ovf}, 64'h1);
    run_check(32'h8000_0000, 32'h0, 32'hFFFF_FFFF, 1'b1, 1'b1, "R4 -2^63/-1");
    run_check(32'hFFFF_FFFF, 32'h7FFF_FFFF, 32'd1, 1'b1, 1'b1, "R5 -2^31-1");
    chk(result == 64'hFFFF_FFFF_8000_0000 && ovf, "R5 neg clamp flagged", result, 64'hFFFF_FFFF_8000_0000);
    run_check(32'h8000_0000, 32'h0, 32'd3, 1'b1, 1'b1, "R5 large negative");
  endtask

  task automatic t_flags;
    run_check(32'd5, 32'h0, 32'd2, 1'b0, 1'b1, "R7 set");
    run_check(32'h0, 32'd8, 32'd2, 1'b0, 1'b0, "R8 hold after no-clamp");
    chk(ovf == 1'b1, "R8 ovf kept", {63'h0, ovf}, 64'h1);
    run_check(32'h0, 32'd8, 32'd2, 1'b0, 1'b1, "R7 clear");
    run_check(32'd5, 32'h0, 32'd2, 1'b0, 1'b0, "R8 hold after clamp");
    chk(ovf == 1'b0, "R8 ovf stays 0", {63'h0, ovf}, 64'h0);
  endtask

  task automatic t_div_zero;
    int lat; logic b1;
    logic [63:0] prev;
    run_check(32'd5, 32'h0, 32'd2, 1'b0, 1'b1, "R6 setup");
    prev = result;
    do_div(32'h0, 32'd77, 32'h0, 1'b0, 1'b1, lat, b1);
    chk(div_zero == 1'b1, "R6 fault with done", {63'h0, div_zero}, 64'h1);
    chk(result == prev, "R6 result held", result, prev);
    chk(ovf == 1'b1, "R6 ovf held", {63'h0, ovf}, 64'h1);
    chk(lat == 2 && b1, "R9 zero latency", 64'(lat), 64'd2);
    @(negedge clk);
    chk(!done && !div_zero, "R9 done one cycle", {62'h0, done, div_zero}, 64'h0);
  endtask

  task automatic t_busy_ignore;
    int lat;
    @(negedge clk);
    op_y = 0; op_a = 32'd1000; op_b = 32'd10; signed_op = 0; set_flags = 0; start = 1'b1;
    lat = 0;
    while (1) begin
      @(negedge clk);
      lat++;
      start = 1'b0;
      if (lat == 10) begin
        op_a = 32'd999; op_b = 32'd3; signed_op = 1'b1; start = 1'b1;
      end
      if (done || lat > 300) break;
    end
    chk(result == 64'd100, "R10 first operands kept", result, 64'd100);
    chk(lat == 66, "R10 latency unchanged", 64'(lat), 64'd66);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(!busy && !done, "R10 no second op", {62'h0, busy, done}, 64'h0);
    end
  endtask

  task automatic t_sweep;
    logic [31:0] s;
    s = 32'h1357_9BDF;
    for (int i = 0; i < 12; i++) begin
      logic [31:0] y, a, b;
      s = s * 32'd1664525 + 32'd1013904223; y = {8'h0, s[31:8]} >> (i % 24);
      s = s * 32'd1664525 + 32'd1013904223; a = s;
      s = s * 32'd1664525 + 32'd1013904223; b = s | 32'h1;
      if (i % 2 == 1) y = {32{a[31]}};
      run_check(y, a, b, i[0], 1'b1, i[0] ? "R3 sweep" : "R1 sweep");
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R9 actual=%0d expected=%0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_unsigned_basic();
    t_unsigned_sat();
    t_signed_basic();
    t_signed_sat();
    t_flags();
    t_div_zero();
    t_busy_ignore();
    t_sweep();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule